// File: doc/BRIEF.md
# Display Data Channel EDID Read Responder

This block is a register-mapped target that makes a display data channel controller appear to software. Software sets up a transfer by writing a port-select word and a command word. It then polls a status word and pulls EDID bytes out of a data register, four at a time. The block does not move any wires. Instead it runs a small bus-phase machine (idle, data, wait) that is driven only by these register accesses. It answers data reads from an internal 128-byte EDID image that is computed at elaboration time.

The register bus has plain single-cycle strobes and a 2-bit word address: 0 is port select, 1 is command, 2 is status and 3 is data. The target has no back-pressure, so every strobe is accepted in the cycle it is seen. Read data is registered and appears on the cycle after the read strobe, where it is held until the next read. Software must not raise the write and read strobes in the same cycle. A 4-bit monitor-presence input tells the block which of the four ports have a display attached.

Top module: `ddc_edid_responder`

## Requirements
- R1: After reset the status word reads 0x24 (hardware-ready and error set, phase idle), and the port-select, command and data registers read zero.
- R2: Port-select bits 2:0 accept code 5 (port 0), 4 (port 1), 6 (port 2) and 2 (port 3). Code 0 only clears the read session. Any other code leaves every register and the status unchanged.
- R3: A valid port code clears the session, sets phase idle, clears active and sets hardware-ready and wait-phase. It clears the error bit when that port's monitor-presence bit is 1 and sets the error bit otherwise.
- R4: While command bit 0 (read) is set and bytes remain, a data read returns min(remaining, 4) EDID bytes, with the first byte in bits 7:0. Lanes above that count keep their previous contents, and the pointer advances once per byte served. Here remaining = byte count minus pointer. Image byte a is 00 for a of 0 or 7, FF for a from 1 to 6, (37a+11) mod 256 for a from 8 to 126, and at 127 the value that makes all 128 bytes sum to 0 mod 256.
- R5: If 4 or fewer bytes remained before a data read, the phase becomes idle for cycle types 5 and 7 and wait for the other types, and the session (target select, EDID availability, pointer, byte count, cycle type) is cleared. When no bytes remain, a data read returns the stored data unchanged.
- R6: The command word layout is: bit 0 read, bits 7:1 target, bits 15:8 index, bits 24:16 byte count and bits 27:25 cycle type. The cycle types are 0 none, 1 plain with wait, 3 indexed with wait, 4 stop only, 5 plain with stop and 7 indexed with stop; 2 and 6 do nothing. Types 1, 3, 5 and 7 set phase data and set active. Type 4 acts only when the stored command's type is not 0: it clears the session, sets phase idle and clears active.
- R7: Status layout: bit 0 in-use, bit 1 active, bit 2 hardware-ready, bit 3 wait-phase, bit 4 interrupt, bit 5 error, bits 9:8 phase (0 idle, 1 data, 2 wait). A status read returns the current value and then sets in-use. Writing a 1 to bit 0 clears in-use, and every other status bit ignores writes.
- R8: Command bit 31 is the clear-interrupt handshake. While the stored bit 31 is 1, a command write with bit 31 at 0 clears only that stored bit and resets the controller: status becomes hardware-ready, plus error if no EDID is available, and phase becomes idle. A write with bit 31 at 1 is ignored. While the stored bit 31 is 0, a write with bit 31 at 1 clears interrupt and sets hardware-ready.
- R9: Command bit 30 (software-ready) is always stored as 0. When bit 26 is set, the pointer loads from the index field. Target 0x50 selects the EDID target.
- R10: A byte is served as 00, and the pointer does not advance, when no target is selected, when no EDID is available, or when its address is 128 or more.
- R11: Writes to the data register are ignored. A data read while the stored command's bit 0 is 0 returns the stored data unchanged.
- R12: Read data changes only on the cycle after a read strobe and holds otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_rd | input | 1 | Read strobe, one cycle |
| bus_addr | input | 2 | Word address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| mon_present | input | 4 | Monitor attached, one bit per port |

## Verification
The transfer path is run with several command patterns:
- An indexed read that ends in a stop, split into a full four-byte read and a two-byte tail. This separates the lane merge from a plain overwrite, and the idle end phase from the wait end phase.
- A plain read that ends in wait, which checks the other end phase.
- A stop-only command issued once after a real transfer and once after a command with no cycle. This shows whether the guard on the stored cycle type is honoured.
- Reads against an unselected target, against a port with no monitor, and from an index next to the end of the image. These check the three ways a byte falls back to zero without moving the pointer.

Register side effects are checked through readback: the status semaphore, the clear-interrupt handshake in both directions, and the ignored writes.

// File: rtl/ddc_pkg.sv
package ddc_pkg;
  localparam int WORD_W   = 32;
  localparam int CNT_W    = 9;
  localparam int IDX_W    = 8;
  localparam int TGT_W    = 7;

  localparam logic [1:0] A_PORT = 2'd0;
  localparam logic [1:0] A_CMD  = 2'd1;
  localparam logic [1:0] A_STAT = 2'd2;
  localparam logic [1:0] A_DATA = 2'd3;

  localparam int B_CLR_INT = 31;
  localparam int B_SW_RDY  = 30;
  localparam int B_IDX_EN  = 26;

  localparam logic [2:0] CYC_NONE = 3'd0;
  localparam logic [2:0] CYC_STOP = 3'd4;

  localparam logic [TGT_W-1:0] EDID_TARGET = 7'h50;

  localparam logic [1:0] PH_IDLE = 2'd0;
  localparam logic [1:0] PH_DATA = 2'd1;
  localparam logic [1:0] PH_WAIT = 2'd2;

  typedef struct packed {
    logic error;
    logic irq;
    logic wait_ph;
    logic hw_rdy;
    logic active;
    logic in_use;
  } stat_t;

  typedef struct packed {
    logic [CNT_W-1:0] total;
    logic [TGT_W-1:0] target;
    logic [IDX_W-1:0] index;
    logic [2:0]       cycle;
    logic             idx_en;
    logic             clr_int;
    logic             xfer;
    logic             stop_only;
    logic             ends_stop;
  } cmd_t;
endpackage

// File: rtl/ddc_cmd_decode.sv
module ddc_cmd_decode
  import ddc_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  output cmd_t              cmd
);
  always_comb begin
    cmd.total     = word[24:16];
    cmd.target    = word[7:1];
    cmd.index     = word[15:8];
    cmd.cycle     = word[27:25];
    cmd.idx_en    = word[B_IDX_EN];
    cmd.clr_int   = word[B_CLR_INT];
    cmd.stop_only = (word[27:25] == CYC_STOP);
    cmd.ends_stop = (word[27:25] == 3'd5) || (word[27:25] == 3'd7);
    unique case (word[27:25])
      3'd1, 3'd3, 3'd5, 3'd7: cmd.xfer = 1'b1;
      default:                cmd.xfer = 1'b0;
    endcase
  end
endmodule

// File: rtl/ddc_port_map.sv
module ddc_port_map #(
  parameter int NUM_PORTS = 4,
  localparam int PORT_W = $clog2(NUM_PORTS)
) (
  input  logic [2:0]        code,
  output logic              valid,
  output logic              zero,
  output logic [PORT_W-1:0] port
);
  always_comb begin
    zero  = (code == 3'd0);
    valid = 1'b1;
    unique case (code)
      3'd5:    port = PORT_W'(0);
      3'd4:    port = PORT_W'(1);
      3'd6:    port = PORT_W'(2);
      3'd2:    port = PORT_W'(3);
      default: begin
        port  = '0;
        valid = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/ddc_edid_rom.sv
module ddc_edid_rom #(
  parameter int EDID_BYTES = 128,
  localparam int AW = $clog2(EDID_BYTES)
) (
  input  logic [AW-1:0] addr,
  output logic [7:0]    data
);
  function automatic logic [7:0] raw_byte(int a);
    if (a == 0 || a == 7) return 8'h00;
    if (a < 8)            return 8'hFF;
    return 8'(a * 37 + 11);
  endfunction

  function automatic logic [7:0] calc_sum();
    logic [7:0] s;
    s = 8'h00;
    for (int a = 0; a < EDID_BYTES - 1; a++) s = s + raw_byte(a);
    return 8'(8'h00 - s);
  endfunction

  localparam logic [7:0] CHK = calc_sum();

  always_comb begin
    if (int'(addr) == EDID_BYTES - 1) data = CHK;
    else                              data = raw_byte(int'(addr));
  end
endmodule

// File: rtl/ddc_read_packer.sv
module ddc_read_packer #(
  parameter int LANES      = 4,
  parameter int CNT_W      = 9,
  parameter int EDID_BYTES = 128,
  localparam int LEFT_W = CNT_W + 1,
  localparam int AW     = $clog2(EDID_BYTES),
  localparam int DW     = LANES * 8
) (
  input  logic [CNT_W-1:0] ptr,
  input  logic [CNT_W-1:0] total,
  input  logic             ok,
  input  logic [DW-1:0]    old_data,
  output logic [DW-1:0]    new_data,
  output logic [CNT_W-1:0] new_ptr,
  output logic             has_left,
  output logic             last
);
  logic [LEFT_W-1:0] left;
  logic [LANES-1:0]  served;

  assign left     = {1'b0, total} - {1'b0, ptr};
  assign has_left = !left[LEFT_W-1] && (left != '0);
  assign last     = has_left && (left[LEFT_W-2:0] <= (LEFT_W-1)'(LANES));

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [CNT_W:0] addr_i;
    logic [7:0]     rom_i;
    logic           lane_en;
    logic           good;

    assign addr_i  = {1'b0, ptr} + (CNT_W+1)'(i);
    assign lane_en = has_left && (left[LEFT_W-2:0] > (LEFT_W-1)'(i));
    assign good    = ok && (addr_i < (CNT_W+1)'(EDID_BYTES));
    assign served[i] = lane_en && good;

    ddc_edid_rom #(.EDID_BYTES(EDID_BYTES)) u_rom (
      .addr (addr_i[AW-1:0]),
      .data (rom_i)
    );

    assign new_data[i*8 +: 8] = !lane_en ? old_data[i*8 +: 8]
                              : (good ? rom_i : 8'h00);
  end

  always_comb begin
    new_ptr = ptr;
    for (int i = 0; i < LANES; i++) new_ptr = new_ptr + CNT_W'(served[i]);
  end
endmodule

// File: rtl/ddc_edid_responder.sv
module ddc_edid_responder
  import ddc_pkg::*;
#(
  parameter int NUM_PORTS  = 4,
  parameter int EDID_BYTES = 128,
  localparam int PORT_W = $clog2(NUM_PORTS),
  localparam int LANES  = WORD_W / 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_wr,
  input  logic                 bus_rd,
  input  logic [1:0]           bus_addr,
  input  logic [WORD_W-1:0]    bus_wdata,
  output logic [WORD_W-1:0]    bus_rdata,
  input  logic [NUM_PORTS-1:0] mon_present
);
  logic [WORD_W-1:0] port_q, cmd_q, data_q, rdata_q;
  stat_t             stat_q;
  logic [1:0]        phase_q;
  logic              sel_q, avail_q;
  logic [CNT_W-1:0]  ptr_q, total_q;
  logic [2:0]        scyc_q;

  logic [WORD_W-1:0] n_port, n_cmd, n_data, n_rdata;
  stat_t             n_stat;
  logic [1:0]        n_phase;
  logic              n_sel, n_avail;
  logic [CNT_W-1:0]  n_ptr, n_total;
  logic [2:0]        n_scyc;

  cmd_t              cd;
  logic              pm_valid, pm_zero;
  logic [PORT_W-1:0] pm_port;
  logic [WORD_W-1:0] pk_data;
  logic [CNT_W-1:0]  pk_ptr;
  logic              pk_has_left, pk_last;
  logic [WORD_W-1:0] stat_word, data_rd_val;
  logic              rd_active;

  ddc_cmd_decode u_dec (
    .word (bus_wdata),
    .cmd  (cd)
  );

  ddc_port_map #(.NUM_PORTS(NUM_PORTS)) u_pmap (
    .code  (bus_wdata[2:0]),
    .valid (pm_valid),
    .zero  (pm_zero),
    .port  (pm_port)
  );

  ddc_read_packer #(
    .LANES(LANES), .CNT_W(CNT_W), .EDID_BYTES(EDID_BYTES)
  ) u_pack (
    .ptr      (ptr_q),
    .total    (total_q),
    .ok       (sel_q && avail_q),
    .old_data (data_q),
    .new_data (pk_data),
    .new_ptr  (pk_ptr),
    .has_left (pk_has_left),
    .last     (pk_last)
  );

  assign stat_word   = {{(WORD_W-10){1'b0}}, phase_q, 2'b00, stat_q};
  assign rd_active   = cmd_q[0] && pk_has_left;
  assign data_rd_val = rd_active ? pk_data : data_q;

  always_comb begin
    n_port  = port_q;
    n_cmd   = cmd_q;
    n_data  = data_q;
    n_rdata = rdata_q;
    n_stat  = stat_q;
    n_phase = phase_q;
    n_sel   = sel_q;
    n_avail = avail_q;
    n_ptr   = ptr_q;
    n_total = total_q;
    n_scyc  = scyc_q;

    if (bus_wr) begin
      unique case (bus_addr)
        A_PORT: begin
          if (pm_zero || pm_valid) begin
            n_port  = bus_wdata;
            n_sel   = 1'b0;
            n_avail = 1'b0;
            n_ptr   = '0;
            n_total = '0;
            n_scyc  = CYC_NONE;
            if (pm_valid) begin
              n_phase        = PH_IDLE;
              n_stat.active  = 1'b0;
              n_stat.hw_rdy  = 1'b1;
              n_stat.wait_ph = 1'b1;
              if (mon_present[pm_port]) begin
                n_avail      = 1'b1;
                n_stat.error = 1'b0;
              end else begin
                n_stat.error = 1'b1;
              end
            end
          end
        end
        A_CMD: begin
          if (cmd_q[B_CLR_INT]) begin
            if (!cd.clr_int) begin
              n_cmd[B_CLR_INT] = 1'b0;
              n_stat           = '0;
              n_stat.hw_rdy    = 1'b1;
              n_stat.error     = !avail_q;
              n_phase          = PH_IDLE;
            end
          end else begin
            if (cd.clr_int) begin
              n_stat.irq    = 1'b0;
              n_stat.hw_rdy = 1'b1;
            end
            n_total = cd.total;
            if (cd.target == EDID_TARGET) n_sel = 1'b1;
            if (cd.idx_en) n_ptr = CNT_W'(cd.index);
            n_scyc = cd.cycle;
            if (cd.stop_only) begin
              if (cmd_q[27:25] != CYC_NONE) begin
                n_sel         = 1'b0;
                n_avail       = 1'b0;
                n_ptr         = '0;
                n_total       = '0;
                n_scyc        = CYC_NONE;
                n_phase       = PH_IDLE;
                n_stat.active = 1'b0;
              end
            end else if (cd.xfer) begin
              n_phase       = PH_DATA;
              n_stat.active = 1'b1;
            end
            n_cmd = bus_wdata;
            n_cmd[B_SW_RDY] = 1'b0;
          end
        end
        A_STAT: begin
          if (bus_wdata[0]) n_stat.in_use = 1'b0;
        end
        default: ;
      endcase
    end else if (bus_rd) begin
      unique case (bus_addr)
        A_PORT: n_rdata = port_q;
        A_CMD:  n_rdata = cmd_q;
        A_STAT: begin
          n_rdata       = stat_word;
          n_stat.in_use = 1'b1;
        end
        default: begin
          n_rdata = data_rd_val;
          if (rd_active) begin
            n_data = pk_data;
            n_ptr  = pk_ptr;
            if (pk_last) begin
              n_phase = (scyc_q == 3'd5 || scyc_q == 3'd7) ? PH_IDLE : PH_WAIT;
              n_sel   = 1'b0;
              n_avail = 1'b0;
              n_ptr   = '0;
              n_total = '0;
              n_scyc  = CYC_NONE;
            end
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      port_q  <= '0;
      cmd_q   <= '0;
      data_q  <= '0;
      rdata_q <= '0;
      stat_q  <= '{error: 1'b1, irq: 1'b0, wait_ph: 1'b0,
                   hw_rdy: 1'b1, active: 1'b0, in_use: 1'b0};
      phase_q <= PH_IDLE;
      sel_q   <= 1'b0;
      avail_q <= 1'b0;
      ptr_q   <= '0;
      total_q <= '0;
      scyc_q  <= CYC_NONE;
    end else begin
      port_q  <= n_port;
      cmd_q   <= n_cmd;
      data_q  <= n_data;
      rdata_q <= n_rdata;
      stat_q  <= n_stat;
      phase_q <= n_phase;
      sel_q   <= n_sel;
      avail_q <= n_avail;
      ptr_q   <= n_ptr;
      total_q <= n_total;
      scyc_q  <= n_scyc;
    end
  end

  assign bus_rdata = rdata_q;
endmodule

// File: rtl/ddc_edid_responder_chk.sv
module ddc_edid_responder_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_wr,
  input logic        bus_rd,
  input logic [1:0]  bus_addr,
  input logic [31:0] bus_wdata,
  input logic [31:0] bus_rdata,
  input logic [5:0]  stat,
  input logic [1:0]  phase,
  input logic [8:0]  ptr,
  input logic [31:0] cmd,
  input logic [31:0] data
);
  logic bad_code;
  assign bad_code = (bus_wdata[2:0] == 3'd1) || (bus_wdata[2:0] == 3'd3)
                 || (bus_wdata[2:0] == 3'd7);

  a_r12_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata));

  a_r7_inuse_set: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !bus_wr && bus_addr == 2'd2) |=> stat[0]);

  a_r2_bad_code_inert: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 2'd0 && bad_code)
      |=> ($stable(stat) && $stable(phase) && $stable(ptr)));

  a_r9_swrdy_stripped: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 2'd1) |=> !cmd[30]);

  a_r11_data_wr_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 2'd3) |=> $stable(data));

  a_r7_phase_legal: assert property (@(posedge clk) disable iff (!rst_n)
    phase != 2'd3);

  a_r4_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !bus_wr && bus_addr == 2'd3)
      |=> ({1'b0, ptr} <= {1'b0, $past(ptr)} + 10'd4));
endmodule

bind ddc_edid_responder ddc_edid_responder_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .stat      (stat_q),
  .phase     (phase_q),
  .ptr       (ptr_q),
  .cmd       (cmd_q),
  .data      (data_q)
);

// File: tb/ddc_edid_responder_tb.sv
module ddc_edid_responder_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [3:0]  mon_present = 4'b0101;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  logic rd_seen = 1'b0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic [31:0] last_data;

  always #10 clk = ~clk;

  ddc_edid_responder u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .mon_present(mon_present)
  );

  function automatic logic [7:0] eb(int a);
    logic [7:0] s;
    if (a == 127) begin
      s = 8'h00;
      for (int k = 0; k < 127; k++) s = s + eb(k);
      return 8'(8'h00 - s);
    end
    if (a == 0 || a == 7) return 8'h00;
    if (a < 8) return 8'hFF;
    return 8'((a * 37 + 11) % 256);
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, logic [31:0] exp, string tag);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic stat(logic [31:0] exp, string tag);
    wr(2'd2, 32'h1);
    rd(2'd2, exp, tag);
  endtask

  task automatic rd_data(logic [31:0] exp, string tag);
    rd(2'd3, exp, tag);
    last_data = exp;
  endtask

  // R12: a read strobe seen at one edge has its data checked half a cycle later
  always @(posedge clk) rd_seen <= bus_rd;

  always @(negedge clk) begin
    if (rd_seen) begin
      if (exp_q.size() == 0) begin
        checks++; failures++;
        $display("FAIL R12 actual=%h expected=<none>", bus_rdata);
      end else begin
        check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    last_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    stat(32'h24, "R1 status after reset");
    rd(2'd0, 32'h0, "R1 port reg after reset");
    rd(2'd1, 32'h0, "R1 cmd reg after reset");
    rd(2'd3, 32'h0, "R1 data reg after reset");

    rd(2'd2, 32'h25, "R7 in-use set by prior read");
    wr(2'd2, 32'h0);
    rd(2'd2, 32'h25, "R7 write of 0 keeps in-use");
    wr(2'd2, 32'h1);
    rd(2'd2, 32'h24, "R7 write of 1 clears in-use");

    wr(2'd0, 32'h3);
    rd(2'd0, 32'h0, "R2 invalid code not stored");
    stat(32'h24, "R2 invalid code leaves status");

    wr(2'd0, 32'h5);
    rd(2'd0, 32'h5, "R2 code 5 stored");
    stat(32'h0C, "R3 port with monitor");

    wr(2'd1, 32'h0E1610A1);
    rd(2'd1, 32'h0E1610A1, "R6 cmd stored");
    stat(32'h10E, "R6 transfer sets data phase and active");
    rd_data({eb(19), eb(18), eb(17), eb(16)}, "R4 four bytes from index (R9)");
    stat(32'h10E, "R4 phase held with bytes left");
    rd_data({eb(19), eb(18), eb(21), eb(20)}, "R4 tail keeps upper lanes");
    stat(32'h0E, "R5 stop cycle ends idle");
    rd_data(last_data, "R5 nothing left returns stored");

    wr(2'd0, 32'h6);
    stat(32'h0C, "R3 valid select clears active");
    wr(2'd1, 32'h020300A1);
    rd_data({eb(19), eb(2), eb(1), eb(0)}, "R4 plain read from zero");
    stat(32'h20E, "R5 wait cycle ends in wait");

    wr(2'd1, 32'h08000000);
    stat(32'h0C, "R6 stop-only after transfer");

    wr(2'd0, 32'h5);
    wr(2'd1, 32'h000800A1);
    wr(2'd1, 32'h080800A1);
    rd_data({eb(3), eb(2), eb(1), eb(0)}, "R6 stop-only ignored after no-cycle");
    stat(32'h0C, "R6 phase idle kept");

    wr(2'd0, 32'h5);
    wr(2'd1, 32'h0A0400A3);
    stat(32'h10E, "R6 plain stop transfer");
    rd_data(32'h0, "R10 unselected target reads zero");
    stat(32'h0E, "R5 idle after plain stop");

    wr(2'd0, 32'h4);
    stat(32'h2C, "R3 port without monitor sets error");
    wr(2'd1, 32'h0A0400A1);
    rd_data(32'h0, "R10 no EDID reads zero");

    wr(2'd0, 32'h5);
    wr(2'd1, 32'h0E827EA1);
    rd_data({8'h00, 8'h00, eb(127), eb(126)}, "R10 bytes past end are zero");

    wr(2'd3, 32'hDEADBEEF);
    rd(2'd3, last_data, "R11 data write ignored");
    wr(2'd1, 32'h000000A0);
    rd(2'd3, last_data, "R11 non-read mode returns stored");

    wr(2'd1, 32'h400000A1);
    rd(2'd1, 32'h000000A1, "R9 software-ready stripped");

    wr(2'd0, 32'h5);
    wr(2'd1, 32'h80000000);
    rd(2'd1, 32'h80000000, "R8 clear-int bit stored");
    stat(32'h0C, "R8 set handshake keeps ready");
    wr(2'd1, 32'h8E1610A1);
    rd(2'd1, 32'h80000000, "R8 write with bit set ignored");
    stat(32'h0C, "R8 ignored write leaves phase");
    wr(2'd1, 32'h0);
    rd(2'd1, 32'h0, "R8 stored bit cleared");
    stat(32'h04, "R8 controller reset status");

    repeat (3) @(negedge clk);
    check("R12 read data holds without strobe", bus_rdata, 32'h04);
    check("R12 scoreboard drained", 32'(exp_q.size()), 32'd0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule